// File: doc/BRIEF.md
# Banked Memory Map Chip-Select Decoder

This block turns the bus of a processor with a 24-bit address space into active-low device selects and read/write strobes. The upper address byte (the bank) is not on dedicated pins: it appears on the data bus while the clock is low, and the block captures it into a register on every falling clock edge. The following clock-high phase is then decoded against that captured bank together with the sixteen address pins.

Bank 0 is split into a 32 KB RAM, a 16 KB I/O window and a 16 KB ROM. The I/O window is divided into eight 2 KB device selects. A bank-0 gate disables all three of these regions as soon as any bank bit is set. Above bank 0, a 4 MB expansion RAM answers in the lower half of the bank range, with aliases, and a high ROM answers to the top bank bit alone. Each select has its own qualification by clock phase and by the valid-address inputs. A parameter chooses whether the ROM selects follow the clock-high phase or the valid-address qualifiers alone, which gives a slow ROM the whole cycle.

Top module: `bank_cs_decoder`

## Requirements
- R1: On each falling clock edge the data bus is stored as the bank byte. Decoding in the next clock-high phase uses this stored byte, not the live data bus. Reset clears the stored bank to 0x00.
- R2: When the stored bank is not 0x00, `ram_cs_n`, `rom_cs_n` and all eight `io_cs_n` bits stay high.
- R3: In bank 0x00, addresses with A15=0 (0x0000 to 0x7FFF) drive `ram_cs_n` low while the clock is high and VDA or VPA is high.
- R4: In bank 0x00, addresses with A15=1 and A14=0 (0x8000 to 0xBFFF) select I/O. `io_cs_n[n]` goes low for n = A13..A11, taken as a 3-bit number, whenever VDA or VPA is high. `io_rd_n` goes low on reads (rw=1) and `io_wr_n` on writes (rw=0).
- R5: In bank 0x00, addresses with A15=1 and A14=1 (0xC000 to 0xFFFF) drive `rom_cs_n` low.
- R6: Banks 0x01 to 0x7F drive `xram_cs_n` low while the clock is high and VDA or VPA is high. Banks 0x41 to 0x7F are aliases of the 4 MB space.
- R7: Any bank with bit 7 set (0x80 to 0xFF) drives `hrom_cs_n` low, whatever the values of A15..A0.
- R8: `ram_cs_n`, `xram_cs_n`, `mem_we_n`, `io_rd_n` and `io_wr_n` stay high while the clock is low.
- R9: A write (rw=0) to the bank-0 ROM region drives `rom_we_n` low during clock-high only when `rom_wr_en` is 1. With `rom_wr_en`=0 such a write leaves every write strobe high. `rom_we_n` is never driven for any other region.
- R10: With parameter ROM_VALID_QUAL=0, `rom_cs_n` and `hrom_cs_n` need the clock high. With ROM_VALID_QUAL=1 they need only VDA or VPA high, so they also assert while the clock is low.
- R11: When VDA and VPA are both low, every select and every strobe output stays high.
- R12: `mem_oe_n` goes low only on reads (rw=1) of an active RAM, expansion RAM, ROM or high ROM select. `mem_we_n` goes low only on writes (rw=0) of an active RAM or expansion RAM select. At most one of the twelve chip-select lines is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; the bank byte is on the data bus while it is low |
| rst_n | input | 1 | Asynchronous active-low reset of the bank register |
| addr | input | 16 | Address lines A15..A0 |
| data | input | 8 | Data bus, carrying the bank byte during clock-low |
| rw | input | 1 | 1 = read, 0 = write |
| vda | input | 1 | Valid data address qualifier |
| vpa | input | 1 | Valid program address qualifier |
| rom_wr_en | input | 1 | Switch input that allows writes to the bank-0 ROM |
| ram_cs_n | output | 1 | Bank-0 RAM select |
| io_cs_n | output | 8 | I/O device selects, one per 2 KB slot |
| rom_cs_n | output | 1 | Bank-0 ROM select |
| xram_cs_n | output | 1 | Expansion RAM select |
| hrom_cs_n | output | 1 | High ROM select |
| mem_oe_n | output | 1 | Memory output enable for reads |
| mem_we_n | output | 1 | RAM and expansion RAM write strobe |
| rom_we_n | output | 1 | Bank-0 ROM write strobe |
| io_rd_n | output | 1 | I/O read strobe |
| io_wr_n | output | 1 | I/O write strobe |

## Verification
Some rules are checked by the assertions at every clock phase: there is never more than one active select, the bank-0 gate holds, the outputs stay idle when neither qualifier is high, the RAM and I/O strobes stay quiet during clock-low, the ROM write is blocked by the switch, and the high ROM follows bank bit 7. Other behaviour only the bench scenarios can show. These are the exact boundaries of each region across every bank value and every 2 KB slot, and the choice of I/O device. They also include the fact that decoding uses the byte captured at the falling edge and not the bus value after that edge, and the different ROM timing of the two parameter settings.

// File: rtl/bank_cs_pkg.sv
package bank_cs_pkg;

  typedef enum logic [2:0] {
    RGN_NONE = 3'd0,
    RGN_RAM  = 3'd1,
    RGN_IO   = 3'd2,
    RGN_ROM  = 3'd3,
    RGN_XRAM = 3'd4,
    RGN_HROM = 3'd5
  } region_e;

  // Map one bank byte plus the top two address bits to a region.
  function automatic region_e region_of(input logic [7:0] bank, input logic a15, input logic a14);
    region_e r;
    if (bank == 8'h00) begin
      if (!a15)     r = RGN_RAM;
      else if (!a14) r = RGN_IO;
      else          r = RGN_ROM;
    end else if (bank[7]) begin
      r = RGN_HROM;
    end else begin
      r = RGN_XRAM;
    end
    return r;
  endfunction

  // One-of-N select for the I/O slot index, active high.
  function automatic logic [7:0] slot_onehot(input logic [2:0] idx);
    logic [7:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/bank_latch.sv
module bank_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus,
  output logic [W-1:0] bank_q
);
  // The bank byte is valid on the bus during clock-low; keep it at the fall.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else        bank_q <= bus;
  end
endmodule

// File: rtl/region_decode.sv
module region_decode
  import bank_cs_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int ADDR_W = 16,
  parameter int SLOT_W = 3
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [SLOT_W-1:0] slot
);
  localparam int SLOT_LSB = ADDR_W - 2 - SLOT_W;

  always_comb begin
    region = region_of(bank, addr[ADDR_W-1], addr[ADDR_W-2]);
    slot   = addr[SLOT_LSB +: SLOT_W];
  end
endmodule

// File: rtl/strobe_gen.sv
module strobe_gen
  import bank_cs_pkg::*;
#(
  parameter bit ROM_VALID_QUAL = 1'b0,
  parameter int NDEV           = 8,
  parameter int SLOT_W         = 3
) (
  input  logic              phase_hi,
  input  logic              valid,
  input  logic              rw,
  input  logic              rom_wr_en,
  input  region_e           region,
  input  logic [SLOT_W-1:0] slot,
  output logic              ram_cs_n,
  output logic [NDEV-1:0]   io_cs_n,
  output logic              rom_cs_n,
  output logic              xram_cs_n,
  output logic              hrom_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              rom_we_n,
  output logic              io_rd_n,
  output logic              io_wr_n
);
  logic clk_q;   // clock-high and valid address
  logic rom_q;   // qualification picked for the ROM selects
  logic ram_a, xram_a, rom_a, hrom_a, io_a;

  assign clk_q = phase_hi & valid;

  generate
    if (ROM_VALID_QUAL) begin : g_rom_valid
      assign rom_q = valid;
    end else begin : g_rom_clock
      assign rom_q = clk_q;
    end
  endgenerate

  always_comb begin
    ram_a  = (region == RGN_RAM)  & clk_q;
    xram_a = (region == RGN_XRAM) & clk_q;
    rom_a  = (region == RGN_ROM)  & rom_q;
    hrom_a = (region == RGN_HROM) & rom_q;
    io_a   = (region == RGN_IO)   & valid;
  end

  genvar d;
  generate
    for (d = 0; d < NDEV; d++) begin : g_dev
      assign io_cs_n[d] = ~(io_a & (slot == SLOT_W'(d)));
    end
  endgenerate

  assign ram_cs_n  = ~ram_a;
  assign xram_cs_n = ~xram_a;
  assign rom_cs_n  = ~rom_a;
  assign hrom_cs_n = ~hrom_a;
  assign mem_oe_n  = ~(rw & (ram_a | xram_a | rom_a | hrom_a));
  assign mem_we_n  = ~(~rw & (ram_a | xram_a));
  assign rom_we_n  = ~(~rw & rom_wr_en & clk_q & (region == RGN_ROM));
  assign io_rd_n   = ~(io_a & phase_hi & rw);
  assign io_wr_n   = ~(io_a & phase_hi & ~rw);
endmodule

// File: rtl/bank_cs_decoder.sv
module bank_cs_decoder
  import bank_cs_pkg::*;
#(
  parameter bit ROM_VALID_QUAL = 1'b0,
  parameter int BANK_W         = 8,
  parameter int ADDR_W         = 16,
  parameter int SLOT_W         = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [BANK_W-1:0]    data,
  input  logic                 rw,
  input  logic                 vda,
  input  logic                 vpa,
  input  logic                 rom_wr_en,
  output logic                 ram_cs_n,
  output logic [(1<<SLOT_W)-1:0] io_cs_n,
  output logic                 rom_cs_n,
  output logic                 xram_cs_n,
  output logic                 hrom_cs_n,
  output logic                 mem_oe_n,
  output logic                 mem_we_n,
  output logic                 rom_we_n,
  output logic                 io_rd_n,
  output logic                 io_wr_n
);
  localparam int NDEV = 1 << SLOT_W;

  // Named internal wires, also used by the bound checker.
  logic [BANK_W-1:0] bank_q;
  region_e           region;
  logic [SLOT_W-1:0] slot;
  logic              addr_valid;

  assign addr_valid = vda | vpa;

  bank_latch #(.W(BANK_W)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .bus    (data),
    .bank_q (bank_q)
  );

  region_decode #(.BANK_W(BANK_W), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_dec (
    .bank   (bank_q),
    .addr   (addr),
    .region (region),
    .slot   (slot)
  );

  strobe_gen #(.ROM_VALID_QUAL(ROM_VALID_QUAL), .NDEV(NDEV), .SLOT_W(SLOT_W)) u_stb (
    .phase_hi  (clk),
    .valid     (addr_valid),
    .rw        (rw),
    .rom_wr_en (rom_wr_en),
    .region    (region),
    .slot      (slot),
    .ram_cs_n  (ram_cs_n),
    .io_cs_n   (io_cs_n),
    .rom_cs_n  (rom_cs_n),
    .xram_cs_n (xram_cs_n),
    .hrom_cs_n (hrom_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .rom_we_n  (rom_we_n),
    .io_rd_n   (io_rd_n),
    .io_wr_n   (io_wr_n)
  );
endmodule

// File: rtl/bank_cs_checker.sv
module bank_cs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       vda,
  input logic       vpa,
  input logic       rom_wr_en,
  input logic [7:0] bank_q,
  input logic       ram_cs_n,
  input logic [7:0] io_cs_n,
  input logic       rom_cs_n,
  input logic       xram_cs_n,
  input logic       hrom_cs_n,
  input logic       mem_oe_n,
  input logic       mem_we_n,
  input logic       rom_we_n,
  input logic       io_rd_n,
  input logic       io_wr_n
);
  logic [11:0] sel_act;
  assign sel_act = {~ram_cs_n, ~io_cs_n, ~rom_cs_n, ~xram_cs_n, ~hrom_cs_n};

  // Sampled at the falling edge: values are those of the clock-high phase.
  p_one_select_r12: assert property (@(negedge clk) disable iff (!rst_n)
    $countones(sel_act) <= 1);

  p_oe_we_apart_r12: assert property (@(negedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  p_low_mask_r2: assert property (@(negedge clk) disable iff (!rst_n)
    (bank_q != 8'h00) |-> (ram_cs_n && rom_cs_n && (&io_cs_n)));

  p_idle_r11: assert property (@(negedge clk) disable iff (!rst_n)
    !(vda || vpa) |-> ((sel_act == '0) && mem_oe_n && mem_we_n && rom_we_n && io_rd_n && io_wr_n));

  p_rom_guard_r9: assert property (@(negedge clk) disable iff (!rst_n)
    !rom_wr_en |-> rom_we_n);

  p_hrom_bit7_r7: assert property (@(negedge clk) disable iff (!rst_n)
    (bank_q[7] && (vda || vpa)) |-> !hrom_cs_n);

  // Sampled at the rising edge: values are those of the clock-low phase.
  p_low_phase_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ram_cs_n && xram_cs_n && mem_we_n && io_rd_n && io_wr_n);
endmodule

bind bank_cs_decoder bank_cs_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .vda       (vda),
  .vpa       (vpa),
  .rom_wr_en (rom_wr_en),
  .bank_q    (bank_q),
  .ram_cs_n  (ram_cs_n),
  .io_cs_n   (io_cs_n),
  .rom_cs_n  (rom_cs_n),
  .xram_cs_n (xram_cs_n),
  .hrom_cs_n (hrom_cs_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .rom_we_n  (rom_we_n),
  .io_rd_n   (io_rd_n),
  .io_wr_n   (io_wr_n)
);

// File: tb/test_bank_cs_decoder.sv
module test_bank_cs_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic        rw = 1'b1;
  logic        vda = 1'b0;
  logic        vpa = 1'b0;
  logic        rom_wr_en = 1'b0;

  logic        ram_a, rom_a, xram_a, hrom_a, oe_a, we_a, rwe_a, ird_a, iwr_a;
  logic [7:0]  io_a;
  logic        ram_b, rom_b, xram_b, hrom_b, oe_b, we_b, rwe_b, ird_b, iwr_b;
  logic [7:0]  io_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bank_cs_decoder #(.ROM_VALID_QUAL(1'b0)) i_bank_cs_decoder (
    .clk(clk), .rst_n(rst_n), .addr(addr), .data(data), .rw(rw), .vda(vda), .vpa(vpa),
    .rom_wr_en(rom_wr_en), .ram_cs_n(ram_a), .io_cs_n(io_a), .rom_cs_n(rom_a),
    .xram_cs_n(xram_a), .hrom_cs_n(hrom_a), .mem_oe_n(oe_a), .mem_we_n(we_a),
    .rom_we_n(rwe_a), .io_rd_n(ird_a), .io_wr_n(iwr_a));

  bank_cs_decoder #(.ROM_VALID_QUAL(1'b1)) i_bank_cs_decoder_vq (
    .clk(clk), .rst_n(rst_n), .addr(addr), .data(data), .rw(rw), .vda(vda), .vpa(vpa),
    .rom_wr_en(rom_wr_en), .ram_cs_n(ram_b), .io_cs_n(io_b), .rom_cs_n(rom_b),
    .xram_cs_n(xram_b), .hrom_cs_n(hrom_b), .mem_oe_n(oe_b), .mem_we_n(we_b),
    .rom_we_n(rwe_b), .io_rd_n(ird_b), .io_wr_n(iwr_b));

  // Order: ram, io[7:0], rom, xram, hrom, oe, we, rom_we, io_rd, io_wr (all active low).
  function automatic logic [16:0] model(input int bank, input int a, input bit rd, input bit v,
                                        input bit swe, input bit hi, input bit vq);
    bit ram, io, rom, xr, hr, rq;
    logic [7:0] dev;
    int full;
    full = bank * 65536 + a;
    ram = v && hi && full < 32768;
    io  = v && full >= 32768 && full < 49152;
    rq  = vq ? v : (v && hi);
    rom = rq && full >= 49152 && full < 65536;
    xr  = v && hi && bank >= 1 && bank <= 127;
    hr  = rq && bank >= 128;
    dev = 8'hFF;
    if (io) dev[(full - 32768) / 2048] = 1'b0;
    return {~ram, dev, ~rom, ~xr, ~hr,
            ~(rd && (ram || xr || rom || hr)),
            ~(!rd && (ram || xr)),
            ~(!rd && swe && v && hi && full >= 49152 && full < 65536),
            ~(io && hi && rd), ~(io && hi && !rd)};
  endfunction

  function automatic string tag_of(input int bank, input int a, input bit v, input bit hi);
    if (!v)               return "R11";
    if (!hi)              return "R8/R10";
    if (bank >= 128)      return "R7";
    if (bank != 0)        return "R2/R6";
    if (a < 32768)        return "R3";
    if (a < 49152)        return "R4";
    return "R5/R9";
  endfunction

  task automatic compare(input string tag, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s bank=%02h addr=%04h rw=%0b actual=%05h expected=%05h",
               tag, i_bank_cs_decoder.bank_q, addr, rw, act, exp);
    end
  endtask

  function automatic logic [16:0] out_a();
    return {ram_a, io_a, rom_a, xram_a, hrom_a, oe_a, we_a, rwe_a, ird_a, iwr_a};
  endfunction
  function automatic logic [16:0] out_b();
    return {ram_b, io_b, rom_b, xram_b, hrom_b, oe_b, we_b, rwe_b, ird_b, iwr_b};
  endfunction

  // One bus cycle: bank on the data bus before the fall, then address phase.
  task automatic bus_cycle(input int bank, input int a, input bit rd, input bit da,
                           input bit pa, input bit swe, input string tag);
    bit v;
    v = da | pa;
    @(posedge clk); #2;
    data = 8'(bank);
    @(negedge clk); #2;
    data = 8'(bank) ^ 8'hA5;   // R1: bus changes after capture
    addr = 16'(a); rw = rd; vda = da; vpa = pa; rom_wr_en = swe;
    #4;
    compare({tag, " low"}, out_a(), model(bank, a, rd, v, swe, 1'b0, 1'b0));
    compare({tag, " low vq"}, out_b(), model(bank, a, rd, v, swe, 1'b0, 1'b1));
    @(posedge clk); #4;
    compare({tag, " high"}, out_a(), model(bank, a, rd, v, swe, 1'b1, 1'b0));
    compare({tag, " high vq"}, out_b(), model(bank, a, rd, v, swe, 1'b1, 1'b1));
  endtask

  initial begin
    #200000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // Reset state: qualifiers low, nothing asserted.
    repeat (2) @(negedge clk);
    #4;
    compare("R11 reset idle", out_a(), 17'h1FFFF);
    // R1: bank register held at 0 in reset even with a non-zero bus.
    data = 8'h80; addr = 16'h1234; vda = 1'b1; rw = 1'b1;
    @(posedge clk); #4;
    compare("R1 reset bank zero", out_a(), model(0, 16'h1234, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0));
    @(negedge clk); #2;
    rst_n = 1'b1; vda = 1'b0;

    // Directed corners.
    bus_cycle(8'h00, 16'h7FFF, 1'b0, 1'b1, 1'b0, 1'b0, "R3 top of ram write");
    bus_cycle(8'h00, 16'h8000, 1'b1, 1'b0, 1'b1, 1'b0, "R4 io slot0 read");
    bus_cycle(8'h00, 16'hBFFF, 1'b0, 1'b1, 1'b0, 1'b0, "R4 io slot7 write");
    bus_cycle(8'h00, 16'hC000, 1'b0, 1'b1, 1'b0, 1'b0, "R9 rom write blocked");
    bus_cycle(8'h00, 16'hFFFF, 1'b0, 1'b1, 1'b0, 1'b1, "R9 rom write allowed");
    bus_cycle(8'h01, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, "R2 bank1 masks ram");
    bus_cycle(8'h40, 16'hFFFF, 1'b0, 1'b1, 1'b0, 1'b0, "R6 last xram bank");
    bus_cycle(8'h41, 16'h8800, 1'b1, 1'b1, 1'b0, 1'b0, "R6 alias bank");
    bus_cycle(8'h7F, 16'hC000, 1'b0, 1'b1, 1'b0, 1'b1, "R9 no rom_we outside bank0");
    bus_cycle(8'h80, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b0, "R7 hrom bank80");
    bus_cycle(8'hFF, 16'hC000, 1'b1, 1'b1, 1'b1, 1'b0, "R10 hrom timing");
    bus_cycle(8'h00, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, "R11 no qualifier");
    bus_cycle(8'h00, 16'hD000, 1'b1, 1'b1, 1'b0, 1'b0, "R12 rom read oe");

    // Sweep: every bank, every 2 KB slot, mixed qualifiers, rw and switch.
    for (int b = 0; b < 256; b++) begin
      for (int k = 0; k < 32; k++) begin
        int a;
        int c;
        a = k * 2048 + ((b * 7 + k * 13) % 2048);
        c = (b + k) % 4;
        bus_cycle(b, a, 1'((k ^ b) & 1), 1'(c & 1), 1'(c >> 1), 1'(((k >> 1) ^ b) & 1),
                  tag_of(b, a, c != 0, 1'b1));
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule